// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Prescaler

This block divides the system clock down to a slow clock for an analog converter. The high phase and the low phase of the divided clock each have their own length setting, taken from two separate fields of different widths. Software therefore chooses the output frequency and the duty cycle together. The output period runs from 2 system cycles when both fields are zero up to 40 system cycles when both fields are at their maximum.

Phase timing comes from one down counter with terminal detection. When a phase ends, the counter reloads with the field that belongs to the next phase, and the divided clock level flips. A field value takes effect only when its phase is next loaded, so a phase that is already running is never cut short or stretched.

The block also gives a one-cycle strobe on every low-to-high transition of the divided level. Logic in the same clock domain uses this strobe as a clock enable instead of using the divided level as a clock.

Top module: `duty_prescaler`

## Requirements
- R1: While `rst` is sampled high at a rising edge of `clk`, the block drives `clk_level` to 0 and `rise_en` to 0. The low phase that follows reset lasts `lo_time`+1 system cycles, counted from the last reset edge and using the `lo_time` value present at that edge.
- R2: Every high phase of `clk_level` lasts exactly `hi_time`+1 system cycles, for each `hi_time` value from 0 to 31.
- R3: Every low phase of `clk_level` lasts exactly `lo_time`+1 system cycles, for each `lo_time` value from 0 to 7.
- R4: The output period is `hi_time`+`lo_time`+2 system cycles. This gives 2 cycles at the minimum setting and 40 cycles at the maximum.
- R5: `rise_en` is 1 for exactly one system cycle, which is the first cycle in which `clk_level` is 1. It is 0 in every other cycle.
- R6: A change of `hi_time` or `lo_time` during a phase does not change the length of that phase. The new value of a field is used the next time its phase starts, sampled at the clock edge that ends the previous phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_time | input | 5 | High-phase length minus one, in system cycles |
| lo_time | input | 3 | Low-phase length minus one, in system cycles |
| clk_level | output | 1 | Divided clock level (registered) |
| rise_en | output | 1 | One-cycle strobe in the first high cycle of `clk_level` |

## Verification
Both outputs are registered. `clk_level` changes at the clock edge where the counter's terminal state is seen, and `rise_en` changes at that same edge. Neither output depends combinationally on the fields. The bench samples on the falling edge and counts how many consecutive samples hold each level. It treats the falling-edge sample that follows the last reset edge as the first low cycle, so each phase length is read as a whole number of samples and compared with field+1.

Field changes are applied just after the falling-edge sample that starts a phase. At that point the load edge for that phase has already passed. The bench therefore expects the phase in progress to keep the old length and the following phase of the same kind to use the new one.

// File: rtl/dprs_pkg.sv
package dprs_pkg;

  // Wider of two field widths; sizes the shared phase counter.
  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // A field value f yields a phase of f+1 system cycles.
  function automatic int unsigned phase_cycles(input int unsigned f);
    return f + 1;
  endfunction

  // Full output period for a pair of field values.
  function automatic int unsigned period_cycles(input int unsigned hi_f, input int unsigned lo_f);
    return phase_cycles(hi_f) + phase_cycles(lo_f);
  endfunction

endpackage

// File: rtl/dprs_load_sel.sv
module dprs_load_sel #(
  parameter int unsigned HI_W  = 5,
  parameter int unsigned LO_W  = 3,
  parameter int unsigned CNT_W = 5
) (
  input  logic [HI_W-1:0]  hi_f,
  input  logic [LO_W-1:0]  lo_f,
  input  logic             pick_hi,
  output logic [CNT_W-1:0] load_val
);

  logic [CNT_W-1:0] hi_wide;
  logic [CNT_W-1:0] lo_wide;

  // Zero-extend each field into the counter width.
  always_comb begin
    hi_wide = CNT_W'(hi_f);
    lo_wide = CNT_W'(lo_f);
  end

  assign load_val = pick_hi ? hi_wide : lo_wide;

endmodule

// File: rtl/dprs_phase_cnt.sv
module dprs_phase_cnt #(
  parameter int unsigned CNT_W      = 5,
  parameter bit          STORE_COMPL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             term,
  output logic [CNT_W-1:0] count_val
);

  logic [CNT_W-1:0] cnt_q;

  generate
    if (STORE_COMPL) begin : g_compl
      // The register holds the ones' complement of the remaining count.
      // Counting up here is counting down in true form; all ones means zero left.
      always_ff @(posedge clk) begin
        if (load) cnt_q <= ~load_val;
        else      cnt_q <= cnt_q + 1'b1;
      end
      assign term      = &cnt_q;
      assign count_val = ~cnt_q;
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (load) cnt_q <= load_val;
        else      cnt_q <= cnt_q - 1'b1;
      end
      assign term      = (cnt_q == '0);
      assign count_val = cnt_q;
    end
  endgenerate

  // R2 R3: after a load the remaining count equals the loaded length
  assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (count_val == $past(load_val)));

  // R3: between loads the remaining count steps down by one
  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> (count_val == CNT_W'($past(count_val) - 1'b1)));

endmodule

// File: rtl/dprs_edge_gen.sv
module dprs_edge_gen (
  input  logic clk,
  input  logic rst,
  input  logic term,
  output logic level,
  output logic rise
);

  logic level_q;
  logic rise_q;
  logic going_high;

  assign going_high = term && !level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      if (term) level_q <= !level_q;
      rise_q <= going_high;
    end
  end

  assign level = level_q;
  assign rise  = rise_q;

  // R5: the strobe only appears while the level is high
  assert_rise_in_high_R5: assert property (@(posedge clk) disable iff (rst)
    rise_q |-> level_q);

  // R5: the strobe never lasts longer than one cycle
  assert_rise_single_R5: assert property (@(posedge clk) disable iff (rst)
    rise_q |=> !rise_q);

  // R4: the level changes only at the counter's terminal state
  assert_level_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !term |=> $stable(level_q));

  // R5: a low-to-high change always raises the strobe
  assert_rise_follows_R5: assert property (@(posedge clk) disable iff (rst)
    (term && !level_q) |=> (rise_q && level_q));

endmodule

// File: rtl/duty_prescaler.sv
module duty_prescaler #(
  parameter int unsigned HI_W        = 5,
  parameter int unsigned LO_W        = 3,
  parameter bit          STORE_COMPL = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HI_W-1:0] hi_time,
  input  logic [LO_W-1:0] lo_time,
  output logic            clk_level,
  output logic            rise_en
);

  localparam int unsigned CNT_W = dprs_pkg::max_w(HI_W, LO_W);
  localparam int unsigned LEN_W = CNT_W + 1;

  logic             term;
  logic             load;
  logic             pick_hi;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] count_val;
  logic             level;
  logic             rise;

  // Reset loads a low phase. A terminal count loads the opposite phase.
  assign load    = rst || term;
  assign pick_hi = !rst && !level;

  dprs_load_sel #(
    .HI_W (HI_W),
    .LO_W (LO_W),
    .CNT_W(CNT_W)
  ) u_sel (
    .hi_f    (hi_time),
    .lo_f    (lo_time),
    .pick_hi (pick_hi),
    .load_val(load_val)
  );

  dprs_phase_cnt #(
    .CNT_W      (CNT_W),
    .STORE_COMPL(STORE_COMPL)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .term     (term),
    .count_val(count_val)
  );

  dprs_edge_gen u_edge (
    .clk  (clk),
    .rst  (rst),
    .term (term),
    .level(level),
    .rise (rise)
  );

  assign clk_level = level;
  assign rise_en   = rise;

  // Track the length of each phase independently of the counter, for checking only.
  logic [LEN_W-1:0] run_q;
  logic [LEN_W-1:0] want_q;
  always_ff @(posedge clk) begin
    if (load) begin
      run_q  <= '0;
      want_q <= LEN_W'(dprs_pkg::phase_cycles(int'(load_val)));
    end else begin
      run_q  <= run_q + 1'b1;
    end
  end

  // R2 R3 R6: each phase ends exactly at the length captured when it was loaded
  assert_phase_len_R2: assert property (@(posedge clk) disable iff (rst)
    term |-> (LEN_W'(run_q + 1'b1) == want_q));

  // R1: reset leaves the level low
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> (!clk_level && !rise_en));

endmodule

// File: tb/duty_prescaler_tb.sv
module duty_prescaler_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] hi_time = '0;
  logic [2:0] lo_time = '0;
  logic       clk_level;
  logic       rise_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  duty_prescaler u_dut (
    .clk      (clk),
    .rst      (rst),
    .hi_time  (hi_time),
    .lo_time  (lo_time),
    .clk_level(clk_level),
    .rise_en  (rise_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply reset with the given fields. Returns at the falling-edge sample
  // that follows the last reset edge, which is the first low cycle.
  task automatic do_reset(input int h, input int l);
    @(negedge clk);
    hi_time = 5'(h);
    lo_time = 3'(l);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(clk_level == 1'b0, "R1 level in reset", int'(clk_level), 0);
    chk(rise_en == 1'b0, "R1 strobe in reset", int'(rise_en), 0);
    rst = 1'b0;
  endtask

  // Counts the samples at the current level, starting at the current sample.
  // Also counts strobe errors: the strobe is expected only on the first sample
  // of a high run. Returns on the first sample at the other level.
  task automatic run_len(input logic want, output int n, output int rise_err);
    n = 1;
    rise_err = 0;
    if (rise_en !== want) rise_err++;
    forever begin
      @(negedge clk);
      if (clk_level !== want || n > 100) break;
      n++;
      if (rise_en !== 1'b0) rise_err++;
    end
  endtask

  initial begin
    int n;
    int re;
    int lo_n;
    int hi_n;
    // Exhaustive sweep over both fields.
    for (int h = 0; h < 32; h++) begin
      for (int l = 0; l < 8; l++) begin
        do_reset(h, l);
        run_len(1'b0, n, re);
        chk(n == l + 1, "R1 first low phase", n, l + 1);
        run_len(1'b1, hi_n, re);
        chk(hi_n == h + 1, "R2 high phase", hi_n, h + 1);
        chk(re == 0, "R5 strobe on high", re, 0);
        run_len(1'b0, lo_n, re);
        chk(lo_n == l + 1, "R3 low phase", lo_n, l + 1);
        chk(re == 0, "R5 strobe on low", re, 0);
        chk(hi_n + lo_n == h + l + 2, "R4 period", hi_n + lo_n, h + l + 2);
      end
    end

    // R6: changes made during a phase leave that phase unchanged.
    begin
      int cases [4][5] = '{'{3, 2, 10, 6, 1}, '{31, 7, 0, 0, 5}, '{0, 0, 31, 7, 3}, '{12, 4, 5, 1, 7}};
      foreach (cases[i]) begin
        int a = cases[i][0];
        int b = cases[i][1];
        int c = cases[i][2];
        int d = cases[i][3];
        int e = cases[i][4];
        do_reset(a, b);
        run_len(1'b0, n, re);
        chk(n == b + 1, "R6 initial low", n, b + 1);
        // Now on the first high sample; the high load edge has passed.
        hi_time = 5'(c);
        lo_time = 3'(d);
        run_len(1'b1, n, re);
        chk(n == a + 1, "R6 high kept old length", n, a + 1);
        run_len(1'b0, n, re);
        chk(n == d + 1, "R6 low uses new field", n, d + 1);
        run_len(1'b1, n, re);
        chk(n == c + 1, "R6 high uses new field", n, c + 1);
        lo_time = 3'(e);
        run_len(1'b0, n, re);
        chk(n == d + 1, "R6 low kept old length", n, d + 1);
        run_len(1'b1, n, re);
        chk(n == c + 1, "R6 high after low change", n, c + 1);
        chk(re == 0, "R5 strobe after changes", re, 0);
        run_len(1'b0, n, re);
        chk(n == e + 1, "R6 low picks later field", n, e + 1);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule